// File: doc/BRIEF.md
# Power-Good Qualified Reset and Remote Wake Controller

This block decides what an incoming bus reset is allowed to do. While the power-good input is high, an active-low bus reset resets the controller core and, once it is released, asks for the configuration to be reloaded from the serial EEPROM. While power good is low, the same reset only floats the bus-side pins. The core state stays untouched, so the block can keep watching for wake events while the host bus is unpowered.

The block also records whether a configuration EEPROM is fitted. It does this by latching a strapping pin on every clock edge of a qualified reset, so the value taken at the last edge before release is the one kept. A low-power wake mode is entered when power good drops with a magic-packet enable set. In that mode a detected magic packet raises a sticky remote-wake output. A link change raises the same output whenever link-change wake is enabled. Frame parsing and link monitoring sit outside this block and reach it as single-cycle pulses.

Top module: `pg_reset_wake_ctrl`

## Requirements
- R1: A clock edge that sees `bus_rst_n` low and `pwr_good` high sets `core_rst` to 1 after that edge. The same edge clears `wake_mode` and `wake_out`.
- R2: A clock edge that sees `pwr_good` low leaves `core_rst` at 0. A bus reset at that edge does not change `wake_mode`, `wake_out` or `eeprom_present`.
- R3: After each edge, `bus_hiz` equals the inverse of `bus_rst_n` as seen at that edge, whatever the level of `pwr_good`. `wake_out` is never gated by `bus_hiz`.
- R4: `cfg_load_req` is 1 for exactly the one cycle after the edge at which `core_rst` was 1 and `bus_rst_n` is seen high. It stays 0 at every other time, including when a reset is released while `pwr_good` is low.
- R5: On every edge that sees a qualified reset, `eeprom_present` takes the level of `detect_pin`, where 1 means an EEPROM is fitted. At all other edges it holds its value, so the level at the last edge of reset is the one kept.
- R6: An edge that sees `pwr_good` low and any bit of `mp_en` set puts the block in wake mode (`wake_mode` = 1).
- R7: Wake mode is left only at an edge that sees `pwr_good` high and every bit of `mp_en` clear. If `pwr_good` is high while any enable bit is set, the mode is held.
- R8: `magic_seen` at an edge where `wake_mode` is already 1 sets `wake_out` after that edge. When `wake_mode` is 0, `magic_seen` has no effect.
- R9: `link_changed` at an edge with `link_wake_en` high sets `wake_out` after that edge. When `link_wake_en` is low, `link_changed` has no effect.
- R10: `wake_out` stays 1 until an edge sees `wake_clear` or a qualified reset. If a wake event and `wake_clear` arrive at the same edge, `wake_out` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_rst_n | input | 1 | Bus reset, active low |
| pwr_good | input | 1 | Bus power good, high when the host supply is valid |
| mp_en | input | MP_EN_W | Magic-packet wake enable bits; any set bit arms wake mode |
| link_wake_en | input | 1 | Enables wake on link change |
| magic_seen | input | 1 | Single-cycle pulse: a magic packet was detected |
| link_changed | input | 1 | Single-cycle pulse: the link state changed |
| wake_clear | input | 1 | Software clear of the remote-wake output |
| detect_pin | input | 1 | Strapping pin level used for EEPROM detection |
| core_rst | output | 1 | Internal reset, active high, registered |
| cfg_load_req | output | 1 | One-cycle request to load configuration from EEPROM |
| bus_hiz | output | 1 | Tristate control for the bus-side pins |
| wake_mode | output | 1 | Low-power magic-packet wake mode flag |
| wake_out | output | 1 | Sticky remote-wake output |
| eeprom_present | output | 1 | Latched EEPROM detection result |

## Verification
The bench drops power good while the bus reset is held. A design that reset its core regardless of power good would lose wake state and the EEPROM flag there, and it would also issue a spurious load request at release. It changes the strapping pin during the reset, so a design that latched the first edge instead of the last would keep a stale presence flag. It sends magic-packet pulses both outside and inside wake mode, and it places wake events on the same cycle as a software clear. Wrong priority or a missing mode gate would then show as a lost or a spurious wake. Enable bits are changed while power good is high to catch an exit from wake mode that ignores them.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic {
    WM_RUN   = 1'b0,
    WM_SLEEP = 1'b1
  } wake_state_e;
endpackage

// File: rtl/pgw_rst_qual.sv
module pgw_rst_qual (
  input  logic clk,
  input  logic bus_rst_n,
  input  logic pwr_good,
  output logic q_rst,
  output logic core_rst,
  output logic bus_hiz,
  output logic cfg_load_req
);
  // Reset is qualified only when bus power is valid.
  assign q_rst = ~bus_rst_n & pwr_good;

  always_ff @(posedge clk) begin
    core_rst     <= q_rst;
    bus_hiz      <= ~bus_rst_n;
    cfg_load_req <= core_rst & bus_rst_n;
  end

  // Checker arming: two edges so that $past never looks before time zero.
  logic [1:0] arm_q = 2'b00;
  always_ff @(posedge clk) arm_q <= {arm_q[0], 1'b1};

  p_rst_qualified_r1: assert property (@(posedge clk) disable iff (!arm_q[1])
    (!bus_rst_n && pwr_good) |=> core_rst);
  p_rst_blocked_r2: assert property (@(posedge clk) disable iff (!arm_q[1])
    (!pwr_good) |=> !core_rst);
  p_hiz_follows_r3: assert property (@(posedge clk) disable iff (!arm_q[1])
    (!bus_rst_n) |=> bus_hiz);
  p_load_single_r4: assert property (@(posedge clk) disable iff (!arm_q[1])
    cfg_load_req |=> !cfg_load_req);
  p_load_cause_r4: assert property (@(posedge clk) disable iff (!arm_q[1])
    cfg_load_req |-> $past(core_rst));
endmodule

// File: rtl/pgw_eedet.sv
module pgw_eedet (
  input  logic clk,
  input  logic q_rst,
  input  logic detect_pin,
  output logic eeprom_present
);
  // Sampled on every qualified-reset edge: the last edge wins.
  always_ff @(posedge clk) begin
    if (q_rst) eeprom_present <= detect_pin;
  end

  logic arm_q = 1'b0;
  always_ff @(posedge clk) arm_q <= 1'b1;

  p_eedet_capture_r5: assert property (@(posedge clk) disable iff (!arm_q)
    q_rst |=> (eeprom_present == $past(detect_pin)));
  p_eedet_hold_r5: assert property (@(posedge clk) disable iff (!arm_q || q_rst)
    arm_q |=> $stable(eeprom_present));
endmodule

// File: rtl/pgw_wake_mode.sv
module pgw_wake_mode
  import pgw_pkg::*;
#(
  parameter int MP_EN_W = 2
) (
  input  logic               clk,
  input  logic               q_rst,
  input  logic               pwr_good,
  input  logic [MP_EN_W-1:0] mp_en,
  output logic               wake_mode
);
  wake_state_e state_q;
  logic        any_en;

  assign any_en = |mp_en;

  always_ff @(posedge clk) begin
    if (q_rst) begin
      state_q <= WM_RUN;
    end else begin
      case (state_q)
        WM_RUN:   if (!pwr_good && any_en) state_q <= WM_SLEEP;
        WM_SLEEP: if (pwr_good && !any_en) state_q <= WM_RUN;
        default:  state_q <= WM_RUN;
      endcase
    end
  end

  assign wake_mode = (state_q == WM_SLEEP);

  p_enter_r6: assert property (@(posedge clk) disable iff (q_rst)
    (!pwr_good && any_en) |=> wake_mode);
  p_exit_r7: assert property (@(posedge clk) disable iff (q_rst)
    (pwr_good && !any_en) |=> !wake_mode);
  p_hold_r7: assert property (@(posedge clk) disable iff (q_rst)
    (wake_mode && pwr_good && any_en) |=> wake_mode);
endmodule

// File: rtl/pgw_wake_latch.sv
module pgw_wake_latch (
  input  logic clk,
  input  logic q_rst,
  input  logic wake_mode,
  input  logic magic_seen,
  input  logic link_wake_en,
  input  logic link_changed,
  input  logic wake_clear,
  output logic wake_out
);
  logic [1:0] src_hit;

  // One qualifying term per wake source.
  assign src_hit[0] = wake_mode & magic_seen;
  assign src_hit[1] = link_wake_en & link_changed;

  always_ff @(posedge clk) begin
    if (q_rst)           wake_out <= 1'b0;
    else if (|src_hit)   wake_out <= 1'b1;
    else if (wake_clear) wake_out <= 1'b0;
  end

  p_magic_sets_r8: assert property (@(posedge clk) disable iff (q_rst)
    (wake_mode && magic_seen) |=> wake_out);
  p_link_sets_r9: assert property (@(posedge clk) disable iff (q_rst)
    (link_wake_en && link_changed) |=> wake_out);
  p_sticky_r10: assert property (@(posedge clk) disable iff (q_rst)
    (wake_out && !wake_clear) |=> wake_out);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (q_rst)
    (!wake_out && !(wake_mode && magic_seen) && !(link_wake_en && link_changed)) |=> !wake_out);
endmodule

// File: rtl/pg_reset_wake_ctrl.sv
module pg_reset_wake_ctrl #(
  parameter int MP_EN_W = 2
) (
  input  logic               clk,
  input  logic               bus_rst_n,
  input  logic               pwr_good,
  input  logic [MP_EN_W-1:0] mp_en,
  input  logic               link_wake_en,
  input  logic               magic_seen,
  input  logic               link_changed,
  input  logic               wake_clear,
  input  logic               detect_pin,
  output logic               core_rst,
  output logic               cfg_load_req,
  output logic               bus_hiz,
  output logic               wake_mode,
  output logic               wake_out,
  output logic               eeprom_present
);
  logic q_rst;

  pgw_rst_qual u_rst_qual (
    .clk          (clk),
    .bus_rst_n    (bus_rst_n),
    .pwr_good     (pwr_good),
    .q_rst        (q_rst),
    .core_rst     (core_rst),
    .bus_hiz      (bus_hiz),
    .cfg_load_req (cfg_load_req)
  );

  pgw_eedet u_eedet (
    .clk            (clk),
    .q_rst          (q_rst),
    .detect_pin     (detect_pin),
    .eeprom_present (eeprom_present)
  );

  pgw_wake_mode #(.MP_EN_W(MP_EN_W)) u_wake_mode (
    .clk       (clk),
    .q_rst     (q_rst),
    .pwr_good  (pwr_good),
    .mp_en     (mp_en),
    .wake_mode (wake_mode)
  );

  pgw_wake_latch u_wake_latch (
    .clk          (clk),
    .q_rst        (q_rst),
    .wake_mode    (wake_mode),
    .magic_seen   (magic_seen),
    .link_wake_en (link_wake_en),
    .link_changed (link_changed),
    .wake_clear   (wake_clear),
    .wake_out     (wake_out)
  );
endmodule

// File: tb/pg_reset_wake_ctrl_tb.sv
module pg_reset_wake_ctrl_tb;
  localparam int MP_EN_W = 2;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               bus_rst_n, pwr_good, link_wake_en, magic_seen, link_changed;
  logic               wake_clear, detect_pin;
  logic [MP_EN_W-1:0] mp_en;
  logic core_rst, cfg_load_req, bus_hiz, wake_mode, wake_out, eeprom_present;

  pg_reset_wake_ctrl #(.MP_EN_W(MP_EN_W)) u_dut (
    .clk(clk), .bus_rst_n(bus_rst_n), .pwr_good(pwr_good), .mp_en(mp_en),
    .link_wake_en(link_wake_en), .magic_seen(magic_seen), .link_changed(link_changed),
    .wake_clear(wake_clear), .detect_pin(detect_pin), .core_rst(core_rst),
    .cfg_load_req(cfg_load_req), .bus_hiz(bus_hiz), .wake_mode(wake_mode),
    .wake_out(wake_out), .eeprom_present(eeprom_present)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected state
  logic e_core = 1'b0, e_load = 1'b0, e_hiz = 1'b0, e_mode = 1'b0, e_wake = 1'b0, e_ee = 1'b0;

  function automatic logic next_mode(logic q, logic pg, logic [MP_EN_W-1:0] en, logic cur);
    if (q) return 1'b0;                 // R1
    if (!pg && (|en)) return 1'b1;      // R6
    if (pg && !(|en)) return 1'b0;      // R7
    return cur;
  endfunction

  function automatic logic next_wake(logic q, logic mode, logic mg, logic lwe, logic lc,
                                     logic clr, logic cur);
    if (q) return 1'b0;                          // R1
    if ((mode && mg) || (lwe && lc)) return 1'b1; // R8, R9, R10 set wins
    if (clr) return 1'b0;                        // R10
    return cur;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic q;
    @(posedge clk);
    q      = !bus_rst_n && pwr_good;
    e_load = e_core && bus_rst_n;
    e_core = q;
    e_hiz  = !bus_rst_n;
    if (q) e_ee = detect_pin;
    e_wake = next_wake(q, e_mode, magic_seen, link_wake_en, link_changed, wake_clear, e_wake);
    e_mode = next_mode(q, pwr_good, mp_en, e_mode);
    @(negedge clk);
    chk("R1/R2 core_rst", core_rst, e_core);
    chk("R3 bus_hiz", bus_hiz, e_hiz);
    chk("R4 cfg_load_req", cfg_load_req, e_load);
    chk("R5 eeprom_present", eeprom_present, e_ee);
    chk("R6/R7 wake_mode", wake_mode, e_mode);
    chk("R8/R9/R10 wake_out", wake_out, e_wake);
  endtask

  task automatic idle_inputs();
    magic_seen = 0; link_changed = 0; wake_clear = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    bus_rst_n = 0; pwr_good = 1; mp_en = '0; link_wake_en = 0;
    detect_pin = 0; idle_inputs();

    // Reset state; pin changes during reset, last edge decides (R5)
    repeat (3) step();
    chk("R1 reset core_rst", core_rst, 1'b1);
    chk("R1 reset wake_out", wake_out, 1'b0);
    detect_pin = 1;
    step();
    bus_rst_n = 1; detect_pin = 0;
    step();
    chk("R4 load pulse", cfg_load_req, 1'b1);
    chk("R5 last edge kept", eeprom_present, 1'b1);
    step();
    chk("R4 pulse one cycle", cfg_load_req, 1'b0);

    // Magic packet outside wake mode is ignored (R8)
    magic_seen = 1; step(); idle_inputs(); step();
    chk("R8 magic ignored", wake_out, 1'b0);

    // Enter wake mode, reset blocked (R2, R6)
    pwr_good = 0; mp_en = 2'b10; step();
    chk("R6 enter", wake_mode, 1'b1);
    magic_seen = 1; wake_clear = 1; step(); idle_inputs();
    chk("R10 set beats clear", wake_out, 1'b1);
    bus_rst_n = 0; detect_pin = 0; repeat (3) step();
    chk("R2 no core reset", core_rst, 1'b0);
    chk("R2 wake kept", wake_out, 1'b1);
    chk("R3 hiz unpowered", bus_hiz, 1'b1);
    bus_rst_n = 1; step(); step();
    chk("R4 no load unpowered", cfg_load_req, 1'b0);
    chk("R2 eedet kept", eeprom_present, 1'b1);

    // Exit rules (R7)
    pwr_good = 1; step();
    chk("R7 held with enable", wake_mode, 1'b1);
    mp_en = '0; step();
    chk("R7 exit", wake_mode, 1'b0);
    wake_clear = 1; step(); idle_inputs();
    chk("R10 clear", wake_out, 1'b0);

    // Link change gating (R9)
    link_changed = 1; step(); idle_inputs();
    chk("R9 disabled ignored", wake_out, 1'b0);
    link_wake_en = 1; link_changed = 1; step(); idle_inputs();
    chk("R9 link wake", wake_out, 1'b1);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      bus_rst_n    = ($urandom_range(0, 99) >= 6);
      if ($urandom_range(0, 99) < 3) pwr_good = ~pwr_good;
      if ($urandom_range(0, 99) < 6) mp_en = MP_EN_W'($urandom);
      if ($urandom_range(0, 99) < 5) link_wake_en = ~link_wake_en;
      magic_seen   = ($urandom_range(0, 99) < 12);
      link_changed = ($urandom_range(0, 99) < 8);
      wake_clear   = ($urandom_range(0, 99) < 8);
      detect_pin   = 1'($urandom);
      step();
    end
    idle_inputs();
    summary();
  end
endmodule